// File: doc/BRIEF.md
# Masked Scalar-to-Vector Broadcast Unit

This execution unit takes one scalar from a general-purpose register and writes copies of it into every element of a vector destination of up to 512 bits. The element width (8, 16, 32 or 64 bits) is decoded from an opcode byte and a width bit. Each element is controlled by a write-mask bit. A clear mask bit either preserves the old destination element (merge mode) or clears it (zero mode). Everything above the selected vector length is forced to zero.

Some encodings are illegal: a register-specifier field that is not all ones, an unknown opcode, or an unsupported length code. For these the unit raises an invalid-operation flag and returns the old destination unchanged. Each operation is accepted when its valid bit is high, and the result is registered, so it appears one clock later.

Top module: `bcast_unit`

## Requirements
- R1: Element width decode: opcode 0x7A gives 8-bit elements and 0x7B gives 16-bit elements. Opcode 0x7C gives 32-bit elements when the effective width bit is 0, and 64-bit elements when it is 1.
- R2: When `long_mode` is 0 the width bit is treated as 0, so 0x7C always uses 32-bit elements.
- R3: Length code `vlen_sel` 0, 1 and 2 selects 128, 256 and 512 bits. The active element count is the length divided by the element width.
- R4: Every written element receives the low element-width bits of `scalar`. Higher scalar bits have no effect.
- R5: When `no_mask` is 1, every active element is written regardless of `mask`.
- R6: In merge mode (`zero_mode`=0), an active element whose mask bit j is 0 keeps the value of `old_dest`.
- R7: In zero mode (`zero_mode`=1), an active element whose mask bit j is 0 becomes zero.
- R8: Every result bit at or above the selected length is zero, whatever the mask or mode.
- R9: If `vvvv` is not 4'b1111, `bad_op` is 1 and `new_dest` equals `old_dest`.
- R10: The following cases give `bad_op`=1 and `new_dest` equal to `old_dest`: an opcode other than 0x7A/0x7B/0x7C, length code 3, or 0x7A/0x7B with the width bit set in long mode.
- R11: Mask bits at or above the active element count have no effect on the result.
- R12: `out_valid` is high exactly one clock after `in_valid` is high, with the result of that operation. The synchronous active-low reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| scalar | input | 64 | Scalar source value |
| old_dest | input | 512 | Previous destination contents |
| mask | input | 64 | Per-element write mask, bit j for element j |
| no_mask | input | 1 | Treat all mask bits as set |
| zero_mode | input | 1 | 1 = clear unselected elements, 0 = keep them |
| vlen_sel | input | 2 | Vector length code |
| opcode | input | 8 | Operation byte |
| w_bit | input | 1 | Width bit |
| long_mode | input | 1 | 64-bit mode; width bit is honoured only here |
| vvvv | input | 4 | Register field that must be all ones |
| out_valid | output | 1 | Result valid |
| new_dest | output | 512 | New destination value |
| bad_op | output | 1 | Invalid-operation flag |

## Verification
The assertions check on every cycle that the valid bit follows the accepted input by one clock. They also check that a non-all-ones register field always yields the flag together with the unchanged destination. Two further cycle checks cover the 128-bit dword form, whose upper bits must read zero, and the unmasked 512-bit byte form, which must be a full copy of the low scalar byte. The bench scenarios cover what depends on data patterns: merge versus zero behaviour under sparse masks, 64-bit elements in and out of long mode, the fact that mask bits beyond the element count are ignored, and the full set of illegal encodings.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
   typedef enum logic [1:0] {
      ESZ_B = 2'd0,
      ESZ_W = 2'd1,
      ESZ_D = 2'd2,
      ESZ_Q = 2'd3
   } esz_e;

   localparam logic [7:0] OPC_BYTE = 8'h7A;
   localparam logic [7:0] OPC_WORD = 8'h7B;
   localparam logic [7:0] OPC_DQ   = 8'h7C;

   typedef struct packed {
      esz_e       esz;
      logic [1:0] vl_code;
      logic       illegal;
   } dec_s;
endpackage

// File: rtl/bcast_decode.sv
module bcast_decode
   import bcast_pkg::*;
#(
   parameter int MAX_VL = 512
) (
   input  logic [7:0] opcode,
   input  logic       w_bit,
   input  logic       long_mode,
   input  logic [3:0] vvvv,
   input  logic [1:0] vlen_sel,
   output dec_s       dec
);
   logic w_eff;
   logic len_bad;

   assign w_eff   = long_mode & w_bit;
   assign len_bad = (vlen_sel == 2'd3) || ((32'd128 << vlen_sel) > 32'(MAX_VL));

   always_comb begin
      dec.esz     = ESZ_B;
      dec.vl_code = vlen_sel;
      dec.illegal = 1'b0;
      case (opcode)
         OPC_BYTE: begin
            dec.esz = ESZ_B;
            if (w_eff) dec.illegal = 1'b1;
         end
         OPC_WORD: begin
            dec.esz = ESZ_W;
            if (w_eff) dec.illegal = 1'b1;
         end
         OPC_DQ:  dec.esz = w_eff ? ESZ_Q : ESZ_D;
         default: dec.illegal = 1'b1;
      endcase
      if (vvvv != 4'hF) dec.illegal = 1'b1;
      if (len_bad)      dec.illegal = 1'b1;
   end
endmodule

// File: rtl/bcast_lane_ctrl.sv
module bcast_lane_ctrl
   import bcast_pkg::*;
#(
   parameter int MAX_VL = 512,
   localparam int NB     = MAX_VL / 8
) (
   input  esz_e          esz,
   input  logic [1:0]    vl_code,
   input  logic [NB-1:0] mask,
   input  logic          no_mask,
   input  logic          zero_mode,
   output logic [NB-1:0] wr_en,
   output logic [NB-1:0] keep_en
);
   logic [63:0] mask_ext;
   logic [7:0]  vl_bytes;

   assign mask_ext = 64'(mask);
   assign vl_bytes = 8'd16 << vl_code;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      localparam logic [7:0] BIDX = 8'(b);
      logic [7:0] elem;
      logic       in_vl;
      logic       sel;
      assign elem       = BIDX >> esz;
      assign in_vl      = BIDX < vl_bytes;
      assign sel        = no_mask | mask_ext[elem[5:0]];
      assign wr_en[b]   = in_vl & sel;
      assign keep_en[b] = in_vl & ~sel & ~zero_mode;
   end
endmodule

// File: rtl/bcast_replicate.sv
module bcast_replicate
   import bcast_pkg::*;
#(
   parameter int MAX_VL = 512,
   localparam int NB     = MAX_VL / 8
) (
   input  logic [63:0]       scalar,
   input  esz_e              esz,
   output logic [MAX_VL-1:0] rep
);
   function automatic logic [7:0] pick(input logic [63:0] s, input esz_e e, input int b);
      case (e)
         ESZ_B:   pick = s[7:0];
         ESZ_W:   pick = s[8*(b%2) +: 8];
         ESZ_D:   pick = s[8*(b%4) +: 8];
         default: pick = s[8*(b%8) +: 8];
      endcase
   endfunction

   for (genvar b = 0; b < NB; b++) begin : g_rep
      assign rep[b*8 +: 8] = pick(scalar, esz, b);
   end
endmodule

// File: rtl/bcast_unit.sv
module bcast_unit
   import bcast_pkg::*;
#(
   parameter int MAX_VL  = 512,
   localparam int NB      = MAX_VL / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [63:0]       scalar,
   input  logic [MAX_VL-1:0] old_dest,
   input  logic [NB-1:0]     mask,
   input  logic              no_mask,
   input  logic              zero_mode,
   input  logic [1:0]        vlen_sel,
   input  logic [7:0]        opcode,
   input  logic              w_bit,
   input  logic              long_mode,
   input  logic [3:0]        vvvv,
   output logic              out_valid,
   output logic [MAX_VL-1:0] new_dest,
   output logic              bad_op
);
   if (MAX_VL != 128 && MAX_VL != 256 && MAX_VL != 512) begin : g_bad_param
      $error("bcast_unit: MAX_VL must be 128, 256 or 512");
   end

   dec_s              dec;
   logic [NB-1:0]     wr_en;
   logic [NB-1:0]     keep_en;
   logic [MAX_VL-1:0] rep;
   logic [MAX_VL-1:0] nxt;

   bcast_decode #(.MAX_VL(MAX_VL)) u_dec (
      .opcode(opcode), .w_bit(w_bit), .long_mode(long_mode),
      .vvvv(vvvv), .vlen_sel(vlen_sel), .dec(dec)
   );

   bcast_lane_ctrl #(.MAX_VL(MAX_VL)) u_lane (
      .esz(dec.esz), .vl_code(dec.vl_code), .mask(mask), .no_mask(no_mask),
      .zero_mode(zero_mode), .wr_en(wr_en), .keep_en(keep_en)
   );

   bcast_replicate #(.MAX_VL(MAX_VL)) u_rep (
      .scalar(scalar), .esz(dec.esz), .rep(rep)
   );

   for (genvar b = 0; b < NB; b++) begin : g_merge
      assign nxt[b*8 +: 8] = dec.illegal ? old_dest[b*8 +: 8] :
                             wr_en[b]    ? rep[b*8 +: 8]      :
                             keep_en[b]  ? old_dest[b*8 +: 8] : 8'h00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         new_dest <= nxt;
         bad_op   <= dec.illegal;
      end
   end

   // R12
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R12
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R9
   field_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vvvv != 4'hF) |=> bad_op);
   // R9
   field_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vvvv != 4'hF) |=> (new_dest == $past(old_dest)));
   // R8
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vvvv == 4'hF && opcode == OPC_DQ && !w_bit && vlen_sel == 2'd0)
      |=> (new_dest[MAX_VL-1:128] == '0));
   // R5
   full_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vvvv == 4'hF && opcode == OPC_BYTE && !w_bit && no_mask &&
       32'(128 << vlen_sel) == 32'(MAX_VL))
      |=> (new_dest == {NB{$past(scalar[7:0])}}));
endmodule

// File: tb/bcast_unit_tb_top.sv
module bcast_unit_tb_top;
   localparam int PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [63:0]  scalar;
   logic [511:0] old_dest;
   logic [63:0]  mask;
   logic         no_mask, zero_mode, w_bit, long_mode;
   logic [1:0]   vlen_sel;
   logic [7:0]   opcode;
   logic [3:0]   vvvv;
   logic         out_valid, bad_op;
   logic [511:0] new_dest;

   int checks = 0;
   int errors = 0;

   always #(PERIOD/2) clk = ~clk;

   bcast_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .scalar(scalar),
      .old_dest(old_dest), .mask(mask), .no_mask(no_mask), .zero_mode(zero_mode),
      .vlen_sel(vlen_sel), .opcode(opcode), .w_bit(w_bit), .long_mode(long_mode),
      .vvvv(vvvv), .out_valid(out_valid), .new_dest(new_dest), .bad_op(bad_op)
   );

   typedef struct {
      logic [63:0]  s;
      logic [511:0] old;
      logic [63:0]  m;
      logic         nm, zm, w, lm;
      logic [1:0]   vl;
      logic [7:0]   op;
      logic [3:0]   vv;
   } stim_t;

   localparam logic [511:0] OLD_PAT = {8{64'hA5C3_1E2D_7788_9F01}};

   function automatic stim_t mk(input logic [7:0] op, input logic [1:0] vl,
                                input logic [63:0] m);
      stim_t t;
      t.s = 64'hF1E2_D3C4_B5A6_9788; t.old = OLD_PAT; t.m = m;
      t.nm = 1'b0; t.zm = 1'b0; t.w = 1'b0; t.lm = 1'b1;
      t.vl = vl; t.op = op; t.vv = 4'hF;
      return t;
   endfunction

   function automatic logic [511:0] model(input stim_t t, output logic bad);
      logic [511:0] r = '0;
      int eb = 1;
      logic weff = t.w & t.lm;
      int vlb = 16 << t.vl;
      bad = (t.vv != 4'hF) || (t.vl == 2'd3);
      case (t.op)
         8'h7A: begin eb = 1; if (weff) bad = 1'b1; end
         8'h7B: begin eb = 2; if (weff) bad = 1'b1; end
         8'h7C: eb = weff ? 8 : 4;
         default: bad = 1'b1;
      endcase
      if (bad) return t.old;
      for (int j = 0; j < vlb / eb; j++) begin
         for (int k = 0; k < eb; k++) begin
            if (t.nm || t.m[j]) r[(j*eb+k)*8 +: 8] = t.s[k*8 +: 8];
            else if (!t.zm)     r[(j*eb+k)*8 +: 8] = t.old[(j*eb+k)*8 +: 8];
         end
      end
      return r;
   endfunction

   task automatic run_op(input stim_t t, input string req);
      logic [511:0] exp_d;
      logic exp_b;
      exp_d = model(t, exp_b);
      @(negedge clk);
      in_valid = 1'b1; scalar = t.s; old_dest = t.old; mask = t.m;
      no_mask = t.nm; zero_mode = t.zm; vlen_sel = t.vl; opcode = t.op;
      w_bit = t.w; long_mode = t.lm; vvvv = t.vv;
      @(negedge clk);
      in_valid = 1'b0;
      checks++;
      if (!out_valid) begin
         errors++; $display("FAIL %s out_valid act=%b exp=1", req, out_valid);
      end
      checks++;
      if (new_dest !== exp_d) begin
         errors++; $display("FAIL %s dest act=%h exp=%h", req, new_dest, exp_d);
      end
      checks++;
      if (bad_op !== exp_b) begin
         errors++; $display("FAIL %s flag act=%b exp=%b", req, bad_op, exp_b);
      end
   endtask

   task automatic t_byte_full();
      stim_t t = mk(8'h7A, 2'd2, 64'h0);
      t.nm = 1'b1;
      run_op(t, "R1 R4 R5 byte 512 no mask");
   endtask

   task automatic t_word_merge();
      stim_t t = mk(8'h7B, 2'd1, 64'hFFFF_FFFF_0000_5A3C);
      run_op(t, "R3 R6 R8 R11 word 256 merge");
   endtask

   task automatic t_dword_zero();
      stim_t t = mk(8'h7C, 2'd0, 64'h0000_0000_0000_0005);
      t.zm = 1'b1;
      run_op(t, "R3 R7 R8 dword 128 zero");
   endtask

   task automatic t_qword();
      stim_t t = mk(8'h7C, 2'd2, 64'h0000_0000_0000_00B6);
      t.w = 1'b1;
      run_op(t, "R1 R4 qword 512 merge");
      t.zm = 1'b1; t.vl = 2'd1; t.m = 64'h9;
      run_op(t, "R1 R3 R7 qword 256 zero");
   endtask

   task automatic t_w_ignored();
      stim_t t = mk(8'h7C, 2'd1, 64'h0000_0000_0000_00A7);
      t.w = 1'b1; t.lm = 1'b0;
      run_op(t, "R2 width bit ignored");
      t.op = 8'h7A;
      run_op(t, "R2 byte legal outside long mode");
   endtask

   task automatic t_mask_high();
      stim_t t = mk(8'h7C, 2'd0, 64'hFFFF_FFFF_FFFF_FFF0);
      run_op(t, "R11 high mask bits ignored");
   endtask

   task automatic t_illegal();
      stim_t t = mk(8'h7A, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
      t.vv = 4'hE;
      run_op(t, "R9 vvvv not all ones");
      t = mk(8'h7D, 2'd2, 64'hF); run_op(t, "R10 bad opcode");
      t = mk(8'h7B, 2'd3, 64'hF); run_op(t, "R10 bad length code");
      t = mk(8'h7A, 2'd0, 64'hF); t.w = 1'b1; run_op(t, "R10 byte with W set");
   endtask

   task automatic t_latency();
      stim_t t = mk(8'h7A, 2'd0, 64'h1);
      run_op(t, "R12 single op");
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++; $display("FAIL R12 idle act=%b exp=0", out_valid);
      end
      in_valid = 1'b1; rst_n = 1'b0;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++; $display("FAIL R12 reset act=%b exp=0", out_valid);
      end
      in_valid = 1'b0; rst_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; scalar = '0; old_dest = '0; mask = '0;
      no_mask = 1'b0; zero_mode = 1'b0; vlen_sel = 2'd0; opcode = 8'h7A;
      w_bit = 1'b0; long_mode = 1'b1; vvvv = 4'hF;
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++; $display("FAIL R12 reset state act=%b exp=0", out_valid);
      end
      rst_n = 1'b1;
      t_byte_full();
      t_word_merge();
      t_dword_zero();
      t_qword();
      t_w_ignored();
      t_mask_high();
      t_illegal();
      t_latency();
      run_op(mk(8'h7B, 2'd2, 64'hAAAA_5555), "R6 word 512 after reset");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(PERIOD * 100000);
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule